// File: doc/BRIEF.md
# Up/Down Pulse Count Integrator

This block sits behind a phase detector in a clock and data recovery loop. On every accepted beat it takes two 7-bit vectors: one marks "early" (up) pulses and one marks "late" (down) pulses. A small tree of full-adder cells counts the ones in each vector. The down count is subtracted from the up count, which gives a signed per-beat error between -7 and +7.

That error is presented on the output for one cycle. It is also summed into a signed accumulator. When the accumulator reaches its most positive or most negative value it stays there instead of wrapping. A synchronous clear input returns the accumulator to zero, and this clear takes priority over any beat offered in the same cycle.

The input side is a valid/ready stream. `in_ready_o` is high in every cycle except one in which `clr_i` is high. A beat is accepted on a rising clock edge when `in_valid_i` and `in_ready_o` are both high. While `clr_i` is high, a valid beat is back-pressured, not accepted, and has no effect on the outputs. The output side has no back-pressure: `out_valid_o` pulses for one cycle per accepted beat.

Top module: `upd_integrator`

## Requirements
- R1: Each count equals the number of ones in its own 7-bit vector (0 to 7). This is observable as `diff_o` = popcount(up) when the down vector is zero, and `diff_o` = -popcount(down) when the up vector is zero.
- R2: After the clock edge that accepts a beat, `diff_o` holds popcount(up) - popcount(down) as a 4-bit two's complement value, and `out_valid_o` is high for that one cycle.
- R3: Each accepted beat adds its `diff_o` value into the signed `acc_o`. The new sum is visible after the same edge that updates `diff_o`.
- R4: If the sum would exceed 2^(ACC_W-1)-1, `acc_o` holds at 2^(ACC_W-1)-1.
- R5: If the sum would fall below -2^(ACC_W-1), `acc_o` holds at -2^(ACC_W-1).
- R6: A clock edge with `clr_i` high sets `acc_o` to zero and drives `out_valid_o` low. `in_ready_o` is low while `clr_i` is high, so a beat offered in that cycle is dropped.
- R7: On a cycle with no accepted beat, `acc_o` and `diff_o` keep their values and `out_valid_o` is low.
- R8: After reset, `acc_o` = 0, `diff_o` = 0 and `out_valid_o` = 0. With `clr_i` low, `in_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous accumulator clear |
| in_valid_i | input | 1 | Input beat valid |
| in_ready_o | output | 1 | Input beat ready (low during clear) |
| up_i | input | 7 | Up pulse vector |
| dn_i | input | 7 | Down pulse vector |
| out_valid_o | output | 1 | One-cycle pulse per accepted beat |
| diff_o | output | 4 | Signed up-minus-down count of the last beat |
| acc_o | output | ACC_W | Signed saturating accumulated error |

## Verification
Reaching either saturation rail is the hard case. The rail must be reached by different step sizes and then held while further beats keep pushing the same way. A slowly drifting accumulator covers neither. The bench sweeps all 16384 up/down vector pairs in an order where the up vector varies slowest. This keeps a positive drift for long stretches and then a negative one, so the accumulator hits both rails many times. The bench then adds runs of all-ones vectors that pin the accumulator against each rail. For every beat, an arithmetic model predicts the count, the difference and the clamped sum.

// File: rtl/upd_pkg.sv
package upd_pkg;
  localparam int VEC_W  = 7;
  localparam int CNT_W  = 3;
  localparam int DIFF_W = CNT_W + 1;
  typedef logic [VEC_W-1:0]         vec_t;
  typedef logic [CNT_W-1:0]         cnt_t;
  typedef logic signed [DIFF_W-1:0] diff_t;
endpackage

// File: rtl/upd_fa_cell.sv
module upd_fa_cell (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic co_o
);
  logic axb;
  assign axb  = a_i ^ b_i;
  assign s_o  = axb ^ c_i;
  assign co_o = (a_i & b_i) | (c_i & axb);
endmodule

// File: rtl/upd_pop7.sv
// Seven-input ones counter built from four full-adder cells in two stages.
module upd_pop7
  import upd_pkg::*;
(
  input  vec_t vec_i,
  output cnt_t cnt_o
);
  logic [1:0] s1, c1;
  logic       k2;

  // stage 1: two groups of three bits -> two 2-bit counts
  for (genvar g = 0; g < 2; g++) begin : g_stage1
    upd_fa_cell fa_i (
      .a_i (vec_i[3*g]),
      .b_i (vec_i[3*g+1]),
      .c_i (vec_i[3*g+2]),
      .s_o (s1[g]),
      .co_o(c1[g])
    );
  end

  // stage 2: add the two 2-bit counts, seventh bit enters as carry-in
  upd_fa_cell fa_lo_i (
    .a_i (s1[0]),
    .b_i (s1[1]),
    .c_i (vec_i[6]),
    .s_o (cnt_o[0]),
    .co_o(k2)
  );
  upd_fa_cell fa_hi_i (
    .a_i (c1[0]),
    .b_i (c1[1]),
    .c_i (k2),
    .s_o (cnt_o[1]),
    .co_o(cnt_o[2])
  );
endmodule

// File: rtl/upd_sat_acc.sv
module upd_sat_acc
  import upd_pkg::*;
#(
  parameter int ACC_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr_i,
  input  logic                    en_i,
  input  diff_t                   delta_i,
  output logic signed [ACC_W-1:0] acc_o
);
  localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};
  localparam int EXT_W = ACC_W + 1 - DIFF_W;

  logic signed [ACC_W-1:0] acc_q, acc_d;
  logic signed [ACC_W:0]   sum;
  logic                    ovf;

  assign sum = {acc_q[ACC_W-1], acc_q} + {{EXT_W{delta_i[DIFF_W-1]}}, delta_i};
  assign ovf = sum[ACC_W] ^ sum[ACC_W-1];

  always_comb begin
    if (!ovf)         acc_d = sum[ACC_W-1:0];
    else if (sum[ACC_W]) acc_d = ACC_MIN;
    else              acc_d = ACC_MAX;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else if (en_i)  acc_q <= acc_d;
  end

  assign acc_o = acc_q;

  AST_ACC_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !clr_i && acc_q == '0) |=> (acc_q == ACC_W'($past(delta_i)))); // R3
  AST_SAT_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !clr_i && acc_q == ACC_MAX && !delta_i[DIFF_W-1]) |=> (acc_q == ACC_MAX)); // R4
  AST_SAT_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !clr_i && acc_q == ACC_MIN && delta_i[DIFF_W-1]) |=> (acc_q == ACC_MIN)); // R5
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (acc_q == '0)); // R6
  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !clr_i) |=> $stable(acc_q)); // R7
endmodule

// File: rtl/upd_integrator.sv
module upd_integrator
  import upd_pkg::*;
#(
  parameter int ACC_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr_i,
  input  logic                    in_valid_i,
  output logic                    in_ready_o,
  input  logic [6:0]              up_i,
  input  logic [6:0]              dn_i,
  output logic                    out_valid_o,
  output logic signed [3:0]       diff_o,
  output logic signed [ACC_W-1:0] acc_o
);
  localparam int NCH = 2; // channel 0 = up, channel 1 = down

  vec_t [NCH-1:0] vec;
  cnt_t [NCH-1:0] cnt;
  diff_t          diff_c, diff_q;
  logic           accept, vld_q;

  assign vec[0] = up_i;
  assign vec[1] = dn_i;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    upd_pop7 pop_i (.vec_i(vec[ch]), .cnt_o(cnt[ch]));
  end

  assign diff_c     = $signed({1'b0, cnt[0]}) - $signed({1'b0, cnt[1]});
  assign in_ready_o = ~clr_i;
  assign accept     = in_valid_i & in_ready_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      diff_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= accept;
      if (accept) diff_q <= diff_c;
    end
  end

  upd_sat_acc #(.ACC_W(ACC_W)) acc_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (clr_i),
    .en_i   (accept),
    .delta_i(diff_c),
    .acc_o  (acc_o)
  );

  assign out_valid_o = vld_q;
  assign diff_o      = diff_q;

  AST_POP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid_i |-> (32'(cnt[0]) == $countones(up_i))); // R1
  AST_POP_DN: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid_i |-> (32'(cnt[1]) == $countones(dn_i))); // R1
  AST_OUT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid_o); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> (!out_valid_o && $stable(diff_o))); // R7
endmodule

// File: tb/upd_integrator_tb.sv
module upd_integrator_tb_top;
  localparam int ACC_W = 8;
  localparam int AMAX  = (1 << (ACC_W-1)) - 1;
  localparam int AMIN  = -(1 << (ACC_W-1));

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, vld = 1'b0;
  logic [6:0] up = '0, dn = '0;
  logic rdy, ovld;
  logic signed [3:0] diff;
  logic signed [ACC_W-1:0] acc;

  int checks = 0, errors = 0, model = 0, model_d = 0;
  bit done = 0;

  always #5 clk = ~clk;

  upd_integrator #(.ACC_W(ACC_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .in_valid_i(vld), .in_ready_o(rdy),
    .up_i(up), .dn_i(dn), .out_valid_o(ovld), .diff_o(diff), .acc_o(acc));

  function automatic int pc(input logic [6:0] v);
    int n = 0;
    for (int i = 0; i < 7; i++) n += v[i];
    return n;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, model the edge, sample after the edge
  task automatic step(input logic c, input logic v, input logic [6:0] u, input logic [6:0] d);
    int s;
    @(negedge clk);
    clr = c; vld = v; up = u; dn = d;
    #1 if (c) chk("R6 ready", int'(rdy), 0);
    if (c) model = 0;
    else if (v) begin
      model_d = pc(u) - pc(d);
      s = model + model_d;
      model = (s > AMAX) ? AMAX : (s < AMIN) ? AMIN : s;
    end
    @(posedge clk); #1;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int s;
    repeat (3) @(posedge clk);
    #1;
    chk("R8 acc", int'(acc), 0);
    chk("R8 diff", int'(diff), 0);
    chk("R8 valid", int'(ovld), 0);
    @(negedge clk) rst_n = 1'b1;
    #1 chk("R8 ready", int'(rdy), 1);

    // R1: each counter alone
    for (int u = 0; u < 128; u++) begin
      step(1'b1, 1'b0, '0, '0);
      step(1'b0, 1'b1, 7'(u), '0);
      chk("R1 up count", int'(diff), pc(7'(u)));
    end
    for (int d = 0; d < 128; d++) begin
      step(1'b1, 1'b0, '0, '0);
      step(1'b0, 1'b1, '0, 7'(d));
      chk("R1 down count", int'(diff), -pc(7'(d)));
    end

    // R2/R3/R4/R5: full sweep, accumulator walks into both rails
    step(1'b1, 1'b0, '0, '0);
    for (int u = 0; u < 128; u++)
      for (int d = 0; d < 128; d++) begin
        step(1'b0, 1'b1, 7'(u), 7'(d));
        chk("R2 diff", int'(diff), pc(7'(u)) - pc(7'(d)));
        chk("R2 valid", int'(ovld), 1);
        chk(model == AMAX ? "R4 acc" : model == AMIN ? "R5 acc" : "R3 acc", int'(acc), model);
      end

    // R4: pin at the positive rail
    for (int i = 0; i < 40; i++) step(1'b0, 1'b1, 7'h7f, '0);
    chk("R4 rail", int'(acc), AMAX);
    step(1'b0, 1'b1, 7'h01, '0);
    chk("R4 hold", int'(acc), AMAX);
    // R5: pin at the negative rail
    for (int i = 0; i < 80; i++) step(1'b0, 1'b1, '0, 7'h7f);
    chk("R5 rail", int'(acc), AMIN);
    step(1'b0, 1'b1, 7'h01, 7'h03);
    chk("R5 hold", int'(acc), AMIN);

    // R7: idle cycles hold state
    step(1'b0, 1'b1, 7'h0f, 7'h01);
    step(1'b0, 1'b0, 7'h7f, '0);
    chk("R7 valid", int'(ovld), 0);
    chk("R7 diff", int'(diff), 3);
    chk("R7 acc", int'(acc), model);

    // R6: clear with a valid beat offered, beat is dropped
    step(1'b1, 1'b1, 7'h7f, '0);
    chk("R6 acc", int'(acc), 0);
    chk("R6 valid", int'(ovld), 0);
    chk("R6 diff", int'(diff), 3);
    step(1'b0, 1'b1, 7'h03, 7'h7f);
    chk("R3 after clear", int'(acc), -5);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule